// File: doc/BRIEF.md
# Eye Scan Controller

This block runs an on-chip eye measurement for one serial lane. It steps a sampling-phase code for a phase interpolator and an offset code for a slicer threshold DAC across a grid. At every grid point it replays the same fixed-length block of pseudo-random stimulus and counts how many slicer decisions come back as one. A count of half the block length means the sample point sits in the middle of the eye. Each count goes into a small result FIFO that a downstream reader drains with a valid/ready handshake.

Two scan kinds are offered. The full scan visits every grid point, with 512 by 512 points when the parameters keep their default values. The quick scan visits six fixed points near the eye centre. After a quick scan the block reports one verdict: it passes only when every count lies within a programmable window around the half-block value. Scan kind, settle time and window are all captured when a start command is accepted. A settle delay follows every code change before counting begins. The scan halts whenever the result FIFO is full.

Top module: `eye_scan_ctrl`

## Requirements
- R1: In a full scan the time index is the outer loop and the voltage index is the inner loop, both from 0 to 2^IDX_W−1. Each code equals its index times 2^(CODE_W−IDX_W). Exactly one count per grid point is delivered, in that order.
- R2: For every point `prbs_en` is high for exactly BLOCK_LEN consecutive cycles. The delivered count is the number of those cycles in which `slicer_in` was 1, from 0 to BLOCK_LEN inclusive.
- R3: After every change of `pi_code` or `dac_code`, `prbs_en` stays low for exactly the captured settle value plus one cycles before it rises. Both codes stay unchanged while `prbs_en` is high.
- R4: A quick scan visits six points, with the time code as the outer loop over 3/8 and 5/8 of the code range and the voltage code as the inner loop over 3/8, 4/8 and 5/8 of the range. One count per point is delivered, in that order.
- R5: When a quick scan ends, `scan_pass` is 1 exactly when every count c satisfies BLOCK_LEN/2 − window ≤ c ≤ BLOCK_LEN/2 + window. When a full scan ends, `scan_pass` is 0.
- R6: Counts leave through `res_valid`/`res_ready` in production order, with none lost and none repeated. While the result FIFO is full the scan waits and both codes are held.
- R7: A `start` that arrives while `busy` is high is ignored. The scan kind, settle value and window of the running scan do not change.
- R8: `busy` rises in the cycle after an accepted start. After the last count has entered the FIFO, `busy` falls and `done` rises in the same cycle. `done` stays high until the next accepted start.
- R9: After reset `busy`, `done`, `scan_pass`, `prbs_en` and `res_valid` are 0, and both codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a scan when the block is not busy |
| fast_mode | input | 1 | 1 selects the six-point quick scan, 0 the full grid |
| settle_cycles | input | SETTLE_W | Settle delay after each code change, captured at start |
| pass_window | input | CNT_W | Allowed distance from BLOCK_LEN/2 for a quick-scan pass, captured at start |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan complete, held until the next start |
| scan_pass | output | 1 | Quick-scan verdict |
| pi_code | output | CODE_W | Phase interpolator code |
| dac_code | output | CODE_W | Slicer offset DAC code |
| prbs_en | output | 1 | Runs the stimulus generator during the counting window |
| slicer_in | input | 1 | Slicer decision sampled each counting cycle |
| res_valid | output | 1 | A count is available |
| res_ready | input | 1 | The reader takes the count |
| res_count | output | CNT_W | Ones-count of the oldest pending point |

## Verification
A new count can be written into the result FIFO in the same cycle that the reader removes an older one, and this is most likely when the FIFO is full or almost full. The bench drives `res_ready` with several patterns: always high, every other cycle, one cycle in four, and held low until the FIFO fills and the scan stops. Pushes and pops therefore meet at many fill levels. The result is judged by comparing the whole drained sequence against counts computed from the bench's own slicer model. The number of counts must equal the number of grid points, and the codes must stay frozen during the stall.

// File: rtl/eye_scan_pkg.sv
package eye_scan_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_COUNT,
      ST_PUSH,
      ST_DONE
   } scan_state_t;

   localparam int QUICK_POINTS = 6;
endpackage

// File: rtl/eye_scan_seq.sv
module eye_scan_seq #(
   parameter int CODE_W = 10,
   parameter int IDX_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic              quick_sel,
   output logic [CODE_W-1:0] pi_code,
   output logic [CODE_W-1:0] dac_code,
   output logic              last_point
);
   localparam int SHIFT = CODE_W - IDX_W;
   localparam logic [IDX_W-1:0] IDX_MAX = '1;
   localparam int EIGHTH = 2 ** (CODE_W - 3);

   logic [IDX_W-1:0]  t_idx, v_idx;
   logic [2:0]        q_idx;
   logic [CODE_W-1:0] t_grid, v_grid;
   logic [CODE_W-1:0] q_t_tab [8];
   logic [CODE_W-1:0] q_v_tab [8];

   // grid index to code: plain copy or scaled by a power of two
   generate
      if (SHIFT == 0) begin : g_unit_step
         assign t_grid = t_idx;
         assign v_grid = v_idx;
      end else begin : g_scaled_step
         assign t_grid = {t_idx, {SHIFT{1'b0}}};
         assign v_grid = {v_idx, {SHIFT{1'b0}}};
      end
   endgenerate

   // quick-scan points: time at 3/8 and 5/8, voltage at 3/8, 4/8 and 5/8
   for (genvar k = 0; k < 8; k++) begin : g_quick
      if (k < eye_scan_pkg::QUICK_POINTS) begin : g_pt
         assign q_t_tab[k] = CODE_W'((3 + 2 * (k / 3)) * EIGHTH);
         assign q_v_tab[k] = CODE_W'((3 + (k % 3)) * EIGHTH);
      end else begin : g_pad
         assign q_t_tab[k] = '0;
         assign q_v_tab[k] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_idx <= '0;
         v_idx <= '0;
         q_idx <= '0;
      end else if (load) begin
         t_idx <= '0;
         v_idx <= '0;
         q_idx <= '0;
      end else if (advance) begin
         if (quick_sel) begin
            q_idx <= q_idx + 3'd1;
         end else if (v_idx == IDX_MAX) begin
            v_idx <= '0;
            t_idx <= t_idx + 1'b1;
         end else begin
            v_idx <= v_idx + 1'b1;
         end
      end
   end

   assign pi_code    = quick_sel ? q_t_tab[q_idx] : t_grid;
   assign dac_code   = quick_sel ? q_v_tab[q_idx] : v_grid;
   assign last_point = quick_sel ? (q_idx == 3'(eye_scan_pkg::QUICK_POINTS - 1))
                                 : (t_idx == IDX_MAX && v_idx == IDX_MAX);
endmodule

// File: rtl/eye_scan_acc.sv
module eye_scan_acc #(
   parameter int BLOCK_LEN = 1024,
   parameter int CNT_W     = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             sample_en,
   input  logic             slicer_in,
   output logic [CNT_W-1:0] ones_cnt,
   output logic             block_last
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BLOCK_LEN - 1);

   logic [CNT_W-1:0] bit_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         ones_cnt <= '0;
      end else if (clear) begin
         bit_cnt  <= '0;
         ones_cnt <= '0;
      end else if (sample_en) begin
         bit_cnt  <= bit_cnt + 1'b1;
         ones_cnt <= ones_cnt + CNT_W'(slicer_in);
      end
   end

   assign block_last = sample_en && (bit_cnt == LAST_BIT);
endmodule

// File: rtl/eye_scan_fifo.sv
module eye_scan_fifo #(
   parameter int DATA_W = 11,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   output logic              full,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic              valid
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (2 ** AW) != DEPTH) begin : g_bad_depth
         $error("eye_scan_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic [AW:0]       fill;
   logic              push_ok, pop_ok;

   assign push_ok = push && !full;
   assign pop_ok  = pop && valid;

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   assign full  = (fill == (AW + 1)'(DEPTH));
   assign valid = (fill != '0);
   assign dout  = mem[rd_ptr];
endmodule

// File: rtl/eye_scan_ctrl.sv
module eye_scan_ctrl #(
   parameter int CODE_W     = 10,
   parameter int IDX_W      = 9,
   parameter int BLOCK_LEN  = 1024,
   parameter int SETTLE_W   = 8,
   parameter int FIFO_DEPTH = 4,
   localparam int CNT_W     = $clog2(BLOCK_LEN + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                fast_mode,
   input  logic [SETTLE_W-1:0] settle_cycles,
   input  logic [CNT_W-1:0]    pass_window,
   output logic                busy,
   output logic                done,
   output logic                scan_pass,
   output logic [CODE_W-1:0]   pi_code,
   output logic [CODE_W-1:0]   dac_code,
   output logic                prbs_en,
   input  logic                slicer_in,
   output logic                res_valid,
   input  logic                res_ready,
   output logic [CNT_W-1:0]    res_count
);
   import eye_scan_pkg::*;

   localparam int HALF = BLOCK_LEN / 2;

   generate
      if (CODE_W < 3) begin : g_bad_code
         $error("eye_scan_ctrl: CODE_W must be at least 3");
      end
      if (IDX_W < 1 || IDX_W > CODE_W) begin : g_bad_idx
         $error("eye_scan_ctrl: IDX_W must lie in 1..CODE_W");
      end
      if (BLOCK_LEN < 2 || (BLOCK_LEN % 2) != 0) begin : g_bad_block
         $error("eye_scan_ctrl: BLOCK_LEN must be even and at least 2");
      end
   endgenerate

   scan_state_t         state;
   logic [SETTLE_W-1:0] settle_cnt, settle_q;
   logic [CNT_W-1:0]    win_q;
   logic                mode_q, pass_q;
   logic                accept, advance, push, fifo_full;
   logic                last_point, acc_last, in_window;
   logic [CNT_W-1:0]    ones_cnt;
   logic [CNT_W:0]      lo_sum, hi_lim;

   assign busy    = (state == ST_SETTLE) || (state == ST_COUNT) || (state == ST_PUSH);
   assign done    = (state == ST_DONE);
   assign accept  = start && !busy;
   assign push    = (state == ST_PUSH) && !fifo_full;
   assign advance = push && !last_point;
   assign prbs_en = (state == ST_COUNT);

   // count within [HALF - window, HALF + window]
   assign lo_sum    = {1'b0, ones_cnt} + {1'b0, win_q};
   assign hi_lim    = (CNT_W + 1)'(HALF) + {1'b0, win_q};
   assign in_window = (lo_sum >= (CNT_W + 1)'(HALF)) && ({1'b0, ones_cnt} <= hi_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         settle_cnt <= '0;
         settle_q   <= '0;
         win_q      <= '0;
         mode_q     <= 1'b0;
         pass_q     <= 1'b0;
      end else begin
         case (state)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  mode_q     <= fast_mode;
                  settle_q   <= settle_cycles;
                  settle_cnt <= settle_cycles;
                  win_q      <= pass_window;
                  pass_q     <= fast_mode;
                  state      <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (settle_cnt == '0) state <= ST_COUNT;
               else                  settle_cnt <= settle_cnt - 1'b1;
            end
            ST_COUNT: begin
               if (acc_last) state <= ST_PUSH;
            end
            ST_PUSH: begin
               if (!fifo_full) begin
                  if (mode_q && !in_window) pass_q <= 1'b0;
                  if (last_point) begin
                     state <= ST_DONE;
                  end else begin
                     state      <= ST_SETTLE;
                     settle_cnt <= settle_q;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign scan_pass = pass_q;

   eye_scan_seq #(
      .CODE_W (CODE_W),
      .IDX_W  (IDX_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .advance    (advance),
      .quick_sel  (mode_q),
      .pi_code    (pi_code),
      .dac_code   (dac_code),
      .last_point (last_point)
   );

   eye_scan_acc #(
      .BLOCK_LEN (BLOCK_LEN),
      .CNT_W     (CNT_W)
   ) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (state == ST_SETTLE),
      .sample_en  (prbs_en),
      .slicer_in  (slicer_in),
      .ones_cnt   (ones_cnt),
      .block_last (acc_last)
   );

   eye_scan_fifo #(
      .DATA_W (CNT_W),
      .DEPTH  (FIFO_DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   (ones_cnt),
      .full  (fifo_full),
      .pop   (res_ready),
      .dout  (res_count),
      .valid (res_valid)
   );
endmodule

// File: rtl/eye_scan_chk.sv
module eye_scan_chk #(
   parameter int CODE_W    = 10,
   parameter int BLOCK_LEN = 1024,
   parameter int SETTLE_W  = 8,
   parameter int CNT_W     = 11
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      start,
   input logic                      busy,
   input logic                      done,
   input logic                      prbs_en,
   input logic [CODE_W-1:0]         pi_code,
   input logic [CODE_W-1:0]         dac_code,
   input logic                      res_valid,
   input logic [CNT_W-1:0]          res_count,
   input logic [SETTLE_W-1:0]       settle_q,
   input logic                      mode_q,
   input logic                      fifo_full,
   input eye_scan_pkg::scan_state_t state
);
   logic [15:0]    low_run;
   logic [CNT_W:0] high_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= '0;
         high_run <= '0;
      end else if (prbs_en) begin
         low_run <= '0;
         if (high_run != '1) high_run <= high_run + 1'b1;
      end else begin
         high_run <= '0;
         if (low_run != '1) low_run <= low_run + 1'b1;
      end
   end

   // R8
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);

   // R3
   codes_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prbs_en && $past(prbs_en) |-> $stable(pi_code) && $stable(dac_code));

   // R3
   settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prbs_en) |-> int'(low_run) >= int'(settle_q) + 1);

   // R2
   block_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prbs_en) |-> int'(high_run) == BLOCK_LEN);

   // R2
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> int'(res_count) <= BLOCK_LEN);

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full && state == eye_scan_pkg::ST_PUSH |=> $stable(pi_code) && $stable(dac_code));

   // R7
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> $stable(mode_q) && $stable(settle_q));
endmodule

bind eye_scan_ctrl eye_scan_chk #(
   .CODE_W    (CODE_W),
   .BLOCK_LEN (BLOCK_LEN),
   .SETTLE_W  (SETTLE_W),
   .CNT_W     (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .prbs_en   (prbs_en),
   .pi_code   (pi_code),
   .dac_code  (dac_code),
   .res_valid (res_valid),
   .res_count (res_count),
   .settle_q  (settle_q),
   .mode_q    (mode_q),
   .fifo_full (fifo_full),
   .state     (state)
);

// File: tb/tb_eye_scan_ctrl.sv
module tb_eye_scan_ctrl;
   localparam int CODE_W   = 4;
   localparam int IDX_W    = 2;
   localparam int BLOCK    = 16;
   localparam int SETTLE_W = 4;
   localparam int DEPTH    = 4;
   localparam int CNT_W    = 5;
   localparam int STEP     = 4;
   localparam int NVEC     = 5;

   // {quick, settle[3:0], window[4:0], ready_mode[1:0]}
   localparam logic [11:0] VEC [NVEC] = '{
      {1'b0, 4'd0, 5'd0,  2'd0},
      {1'b0, 4'd3, 5'd0,  2'd1},
      {1'b1, 4'd1, 5'd6,  2'd0},
      {1'b1, 4'd2, 5'd5,  2'd2},
      {1'b1, 4'd0, 5'd31, 2'd1}
   };

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic                fast_mode = 1'b0;
   logic [SETTLE_W-1:0] settle_cycles = '0;
   logic [CNT_W-1:0]    pass_window = '0;
   logic                busy, done, scan_pass, prbs_en, res_valid;
   logic [CODE_W-1:0]   pi_code, dac_code;
   logic                slicer_in = 1'b0;
   logic                res_ready = 1'b0;
   logic [CNT_W-1:0]    res_count;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int rmode = 0;
   int cur_settle = 0;
   int n_got = 0;
   int got [64];
   int expv [64];
   int n_exp = 0;
   int k_bits = 0;

   eye_scan_ctrl #(
      .CODE_W     (CODE_W),
      .IDX_W      (IDX_W),
      .BLOCK_LEN  (BLOCK),
      .SETTLE_W   (SETTLE_W),
      .FIFO_DEPTH (DEPTH)
   ) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .fast_mode     (fast_mode),
      .settle_cycles (settle_cycles),
      .pass_window   (pass_window),
      .busy          (busy),
      .done          (done),
      .scan_pass     (scan_pass),
      .pi_code       (pi_code),
      .dac_code      (dac_code),
      .prbs_en       (prbs_en),
      .slicer_in     (slicer_in),
      .res_valid     (res_valid),
      .res_ready     (res_ready),
      .res_count     (res_count)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int thr(input int p, input int d);
      return (p * 3 + d) % (BLOCK + 1);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // slicer model: first thr(codes) samples of each window read 1
   always @(negedge clk) begin
      if (prbs_en) begin
         slicer_in = (k_bits < thr(int'(pi_code), int'(dac_code)));
         k_bits++;
      end else begin
         slicer_in = 1'b0;
         k_bits = 0;
      end
   end

   // reader: decides ready here, records what the next edge pops
   always @(negedge clk) begin
      bit rdy;
      case (rmode)
         0:       rdy = 1'b1;
         1:       rdy = (cyc % 2) == 0;
         2:       rdy = (cyc % 4) == 0;
         default: rdy = 1'b0;
      endcase
      if (rst_n && res_valid && rdy && n_got < 64) begin
         got[n_got] = int'(res_count);
         n_got++;
      end
      res_ready = rdy;
   end

   // R3 monitor: low cycles after a code change until prbs_en rises
   logic [CODE_W-1:0] last_pi = '0, last_dac = '0;
   int  gap = 0;
   bit  armed = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (pi_code != last_pi || dac_code != last_dac) begin
            armed = 1'b1;
            gap = 1;
         end else if (armed && !prbs_en) begin
            gap++;
         end else if (armed && prbs_en) begin
            chk(gap == cur_settle + 1, "R3", "settle gap", gap, cur_settle + 1);
            armed = 1'b0;
         end
      end
      last_pi  = pi_code;
      last_dac = dac_code;
   end

   task automatic build_exp(input bit quick);
      n_exp = 0;
      if (quick) begin
         for (int i = 0; i < 2; i++)
            for (int j = 0; j < 3; j++) begin
               expv[n_exp] = thr((3 + 2 * i) * 2, (3 + j) * 2);
               n_exp++;
            end
      end else begin
         for (int t = 0; t < 4; t++)
            for (int v = 0; v < 4; v++) begin
               expv[n_exp] = thr(t * STEP, v * STEP);
               n_exp++;
            end
      end
   endtask

   task automatic start_scan(input bit quick, input int settle, input int win, input int mode);
      @(negedge clk);
      n_got         = 0;
      rmode         = mode;
      cur_settle    = settle;
      fast_mode     = quick;
      settle_cycles = SETTLE_W'(settle);
      pass_window   = CNT_W'(win);
      start         = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1 && done == 1'b0, "R8", "busy after start", int'(busy), 1);
   endtask

   task automatic finish_scan(input bit quick, input int win);
      int  w;
      bit  exp_pass;
      build_exp(quick);
      w = 0;
      while (!done && w < 3000) begin
         @(negedge clk);
         w++;
      end
      chk(done == 1'b1 && busy == 1'b0, "R8", "done at scan end", int'(done), 1);
      w = 0;
      while (n_got < n_exp && w < 600) begin
         @(negedge clk);
         w++;
      end
      repeat (6) @(negedge clk);
      chk(n_got == n_exp && !res_valid, "R6", "result count", n_got, n_exp);
      for (int i = 0; i < n_exp; i++)
         chk(got[i] == expv[i], quick ? "R4" : "R1", "point count", got[i], expv[i]);
      if (!quick) begin
         chk(got[0] == 0, "R2", "all-zero point", got[0], 0);
         chk(got[5] == BLOCK, "R2", "all-one point", got[5], BLOCK);
      end
      exp_pass = quick;
      if (quick)
         for (int i = 0; i < n_exp; i++)
            if (expv[i] < BLOCK / 2 - win || expv[i] > BLOCK / 2 + win) exp_pass = 1'b0;
      chk(scan_pass == exp_pass, "R5", "verdict", int'(scan_pass), int'(exp_pass));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [CODE_W-1:0] hold_pi, hold_dac;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(!busy && !done && !scan_pass, "R9", "status after reset", int'(busy || done || scan_pass), 0);
      chk(!prbs_en && !res_valid, "R9", "outputs after reset", int'(prbs_en || res_valid), 0);
      chk(pi_code == '0 && dac_code == '0, "R9", "codes after reset", int'(pi_code), 0);

      for (int n = 0; n < NVEC; n++) begin
         start_scan(VEC[n][11], int'(VEC[n][10:7]), int'(VEC[n][6:2]), int'(VEC[n][1:0]));
         finish_scan(VEC[n][11], int'(VEC[n][6:2]));
      end

      // R7: second start with other settings during a full scan
      start_scan(1'b0, 3, 0, 0);
      repeat (30) @(negedge clk);
      fast_mode = 1'b1;
      settle_cycles = '0;
      pass_window = CNT_W'(31);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R7", "busy kept after ignored start", int'(busy), 1);
      finish_scan(1'b0, 0);

      // R6: reader stalled until the FIFO fills
      start_scan(1'b0, 1, 0, 3);
      repeat (300) @(negedge clk);
      chk(busy && !done && res_valid, "R6", "stalled while full", int'(busy), 1);
      chk(pi_code == 4'd4 && dac_code == 4'd0, "R6", "stall point code", int'(pi_code), 4);
      hold_pi  = pi_code;
      hold_dac = dac_code;
      repeat (40) @(negedge clk);
      chk(pi_code == hold_pi && dac_code == hold_dac && !prbs_en, "R6", "codes held in stall",
          int'(dac_code), int'(hold_dac));
      chk(n_got == 0, "R6", "nothing popped without ready", n_got, 0);
      rmode = 0;
      finish_scan(1'b0, 0);

      // R8: done held, cleared by a new start
      repeat (20) @(negedge clk);
      chk(done && !busy, "R8", "done held", int'(done), 1);
      start_scan(1'b1, 0, 6, 0);
      chk(done == 1'b0, "R8", "done cleared by start", int'(done), 0);
      finish_scan(1'b1, 6);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule